// File: doc/BRIEF.md
# Graphics Aperture Address Translator

The block sits in the path of 40-bit memory requests and gives graphics memory a contiguous view. It defines a window in the physical address space called the aperture. A request that falls inside the window is redirected onto a 4 KB page chosen by an entry in a page table, and that table lives in system memory. Any request outside the window, or any request that arrives while translation is switched off for its source, leaves the block one cycle later with its address unchanged.

Software sets the block up through a 32-bit register port. That port holds:
- an enable;
- a per-source disable for CPU and IO requests;
- the aperture size order and base;
- the table base;
- a cache-control word with a self-clearing invalidate bit and a sticky entry-error bit.

When a request misses, the block reads one 32-bit entry over a simple valid/ready read port and decodes it. If the entry is valid, the block keeps it in a small fully associative cache, so a later access to the same page is answered without a memory read.

Top module: `aprt_xlate`

## Requirements
- R1: After reset every register reads zero. The writable fields read back at their offsets and all other bits read zero:
  - 0x90 keeps bits 5:0 (bit 0 enable, bits 3:1 size order, bit 4 CPU disable, bit 5 IO disable).
  - 0x94 keeps bits 14:0.
  - 0x98 keeps bits 31:4.
  - 0x9C bit 0 shows a pending invalidate and bit 1 shows the entry error.
- R2: A request passes through untranslated if the enable is 0, if its source is disabled, or if it lies outside the aperture. It is answered on the cycle after acceptance with the same address, rsp_err 0 and rsp_coh 0, and no table read is made.
- R3: The aperture starts at the 0x94 field shifted left by 25. It spans 32 MB shifted left by the order (0 to 6). The first and last byte are inside; the byte below the start and the byte at start plus span are outside.
- R4: A missing page reads the entry at (0x98 field shifted left by 12) + ((address − aperture start) >> 12) × 4. mem_req_valid and mem_req_addr hold steady until mem_req_ready is seen.
- R5: A fetched entry with bit 0 set produces rsp_addr = {entry[11:4], entry[31:12], request[11:0]} and rsp_coh = entry bit 1. rsp_valid rises on the cycle after mem_rsp_valid.
- R6: A fetched entry with bit 0 clear answers with rsp_err 1 and the original address, sets 0x9C bit 1, and is not cached, so a repeat access reads the table again.
- R7: The entry-error bit stays set until 1 is written to 0x9C bit 1. Writing 0 there leaves it set.
- R8: A valid entry is cached under its page number; a later access to that page is answered on the next cycle with no table read. The cache holds CACHE_ENTRIES pages and replaces them in fill order (round robin).
- R9: Writing 1 to 0x9C bit 0 makes that bit read 1 and holds req_ready low. Once the block is idle the cache is emptied and the bit returns to 0, so a later access reads the table again.
- R10: req_io = 1 marks an IO request and req_io = 0 a CPU request. Register 0x90 bit 4 disables translation for CPU requests and bit 5 for IO requests.
- R11: At most one request is in flight. req_ready is low while a table read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 40 | Request address |
| req_io | input | 1 | Source: 1 IO, 0 CPU |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_addr | output | 40 | Translated or forwarded address |
| rsp_err | output | 1 | Entry was invalid |
| rsp_coh | output | 1 | Coherent flag of the entry used |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 40 | Entry address |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 32 | Entry data |

## Verification
The assertions check several behaviours on every cycle:
- the pass-through response for a bypassed request;
- the single-cycle, read-free answer on a cache hit;
- a steady read request under back-pressure;
- no more than one cache way matching;
- the stickiness of the error bit;
- req_ready held low while an invalidate is pending.

Only the bench scenarios can show the rest, because these depend on state built up over many requests:
- the translated address and coherent flag for each entry;
- the entry address arithmetic;
- the aperture edges for different orders;
- round-robin eviction;
- a refetch after an invalidate.

// File: rtl/aprt_pkg.sv
package aprt_pkg;
  localparam int PA_W    = 40;
  localparam int PG_SH   = 12;
  localparam int PN_W    = PA_W - PG_SH;
  localparam int BASE_SH = 25;
  localparam int BASE_FW = PA_W - BASE_SH;
  localparam int TBL_FW  = 28;

  localparam logic [7:0] OFS_CTL  = 8'h90;
  localparam logic [7:0] OFS_BASE = 8'h94;
  localparam logic [7:0] OFS_TBL  = 8'h98;
  localparam logic [7:0] OFS_CCTL = 8'h9C;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_WAIT} walk_st_e;

  // packed MSB first so that it lines up with register bits 5:0
  typedef struct packed {
    logic       io_off;
    logic       cpu_off;
    logic [2:0] order;
    logic       en;
  } ap_ctl_t;

  function automatic logic [PA_W-1:0] ap_base(input logic [BASE_FW-1:0] f);
    return {f, {BASE_SH{1'b0}}};
  endfunction

  function automatic logic [PA_W-1:0] ap_span(input logic [2:0] ord);
    logic [PA_W-1:0] one;
    one = PA_W'(1);
    return one << (BASE_SH + int'(ord));
  endfunction

  function automatic logic ap_inside(input logic [PA_W-1:0] a,
                                     input logic [BASE_FW-1:0] f,
                                     input logic [2:0] ord);
    logic [PA_W:0] lim;
    lim = {1'b0, ap_base(f)} + {1'b0, ap_span(ord)};
    return (a >= ap_base(f)) && ({1'b0, a} < lim);
  endfunction

  function automatic logic [PA_W-1:0] pte_slot(input logic [TBL_FW-1:0] tbl,
                                               input logic [PA_W-1:0] a,
                                               input logic [BASE_FW-1:0] f);
    logic [PA_W-1:0] idx;
    idx = (a - ap_base(f)) >> PG_SH;
    return {tbl, {PG_SH{1'b0}}} + (idx << 2);
  endfunction

  function automatic logic [PN_W-1:0] pte_frame(input logic [31:0] pte);
    return {pte[11:4], pte[31:12]};
  endfunction
endpackage

// File: rtl/aprt_regs.sv
module aprt_regs
  import aprt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [7:0]         cfg_addr,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic               flush_done,
  input  logic               err_set,
  output ap_ctl_t            ctl,
  output logic [BASE_FW-1:0] base_f,
  output logic [TBL_FW-1:0]  tbl_f,
  output logic               inv_pending,
  output logic               err_flag
);
  logic wr_ctl, wr_base, wr_tbl, wr_cctl;
  assign wr_ctl  = cfg_we && (cfg_addr == OFS_CTL);
  assign wr_base = cfg_we && (cfg_addr == OFS_BASE);
  assign wr_tbl  = cfg_we && (cfg_addr == OFS_TBL);
  assign wr_cctl = cfg_we && (cfg_addr == OFS_CCTL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl         <= '0;
      base_f      <= '0;
      tbl_f       <= '0;
      inv_pending <= 1'b0;
      err_flag    <= 1'b0;
    end else begin
      if (wr_ctl)  ctl    <= ap_ctl_t'(cfg_wdata[5:0]);
      if (wr_base) base_f <= cfg_wdata[BASE_FW-1:0];
      if (wr_tbl)  tbl_f  <= cfg_wdata[31:4];
      if (wr_cctl && cfg_wdata[0])  inv_pending <= 1'b1;
      else if (flush_done)          inv_pending <= 1'b0;
      if (err_set)                  err_flag <= 1'b1;
      else if (wr_cctl && cfg_wdata[1]) err_flag <= 1'b0;
    end
  end

  always_comb begin
    unique case (cfg_addr)
      OFS_CTL:  cfg_rdata = {26'b0, ctl};
      OFS_BASE: cfg_rdata = {{(32-BASE_FW){1'b0}}, base_f};
      OFS_TBL:  cfg_rdata = {tbl_f, 4'b0};
      OFS_CCTL: cfg_rdata = {30'b0, err_flag, inv_pending};
      default:  cfg_rdata = '0;
    endcase
  end

  // R7: the error flag only falls on an explicit write-one
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !(wr_cctl && cfg_wdata[1]) |=> err_flag);
  // R9: a completed flush clears the pending bit unless re-armed
  p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done && !(wr_cctl && cfg_wdata[0]) |=> !inv_pending);
endmodule

// File: rtl/aprt_cache.sv
module aprt_cache
  import aprt_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PN_W-1:0] look_pn,
  output logic            hit,
  output logic [PN_W-1:0] hit_frame,
  output logic            hit_coh,
  input  logic            fill,
  input  logic [PN_W-1:0] fill_pn,
  input  logic [PN_W-1:0] fill_frame,
  input  logic            fill_coh,
  input  logic            flush
);
  localparam int PW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PW-1:0] LAST = PW'(ENTRIES - 1);

  logic [ENTRIES-1:0] hit_vec, vld_vec, sel_coh;
  logic [PN_W-1:0]    sel_frame [ENTRIES];
  logic [PW-1:0]      ptr;

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_way
      logic            v_q, c_q;
      logic [PN_W-1:0] t_q, f_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q <= 1'b0; c_q <= 1'b0; t_q <= '0; f_q <= '0;
        end else if (flush) begin
          v_q <= 1'b0;
        end else if (fill && ptr == PW'(g)) begin
          v_q <= 1'b1; c_q <= fill_coh; t_q <= fill_pn; f_q <= fill_frame;
        end
      end
      assign vld_vec[g]   = v_q;
      assign hit_vec[g]   = v_q && (t_q == look_pn);
      assign sel_frame[g] = hit_vec[g] ? f_q : '0;
      assign sel_coh[g]   = hit_vec[g] && c_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr <= '0;
    else if (flush) ptr <= '0;
    else if (fill)  ptr <= (ptr == LAST) ? '0 : ptr + PW'(1);
  end

  always_comb begin
    hit_frame = '0;
    for (int i = 0; i < ENTRIES; i++) hit_frame |= sel_frame[i];
  end
  assign hit     = |hit_vec;
  assign hit_coh = |sel_coh;

  // R8: a page is never held by two ways
  p_single_way_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  // R9: a flush leaves no valid way behind
  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_vec == '0));
endmodule

// File: rtl/aprt_xlate.sv
module aprt_xlate
  import aprt_pkg::*;
#(
  parameter int CACHE_ENTRIES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [7:0]      cfg_addr,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     cfg_rdata,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [PA_W-1:0] req_addr,
  input  logic            req_io,
  output logic            rsp_valid,
  output logic [PA_W-1:0] rsp_addr,
  output logic            rsp_err,
  output logic            rsp_coh,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [PA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [31:0]     mem_rsp_data
);
  ap_ctl_t            ctl;
  logic [BASE_FW-1:0] base_f;
  logic [TBL_FW-1:0]  tbl_f;
  logic               inv_pending, err_flag, flush_done;
  walk_st_e           st_q;
  logic [PA_W-1:0]    hold_q, slot_q;
  logic               c_hit, c_coh;
  logic [PN_W-1:0]    c_frame;

  // named internal events
  logic in_ap, src_off, xl_on, accept, acc_bypass, acc_hit, acc_miss;
  logic pte_ok, pte_bad;

  aprt_regs u_regs (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .flush_done, .err_set(pte_bad), .ctl, .base_f, .tbl_f,
    .inv_pending, .err_flag
  );

  aprt_cache #(.ENTRIES(CACHE_ENTRIES)) u_cache (
    .clk, .rst_n,
    .look_pn(req_addr[PA_W-1:PG_SH]), .hit(c_hit), .hit_frame(c_frame), .hit_coh(c_coh),
    .fill(pte_ok), .fill_pn(hold_q[PA_W-1:PG_SH]),
    .fill_frame(pte_frame(mem_rsp_data)), .fill_coh(mem_rsp_data[1]),
    .flush(flush_done)
  );

  assign in_ap      = ap_inside(req_addr, base_f, ctl.order);
  assign src_off    = req_io ? ctl.io_off : ctl.cpu_off;
  assign xl_on      = ctl.en && !src_off && in_ap;
  assign req_ready  = (st_q == ST_IDLE) && !inv_pending;
  assign accept     = req_valid && req_ready;
  assign acc_bypass = accept && !xl_on;
  assign acc_hit    = accept && xl_on && c_hit;
  assign acc_miss   = accept && xl_on && !c_hit;
  assign pte_ok     = (st_q == ST_WAIT) && mem_rsp_valid && mem_rsp_data[0];
  assign pte_bad    = (st_q == ST_WAIT) && mem_rsp_valid && !mem_rsp_data[0];
  assign flush_done = (st_q == ST_IDLE) && inv_pending;

  assign mem_req_valid = (st_q == ST_FETCH);
  assign mem_req_addr  = slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      hold_q    <= '0;
      slot_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_err   <= 1'b0;
      rsp_coh   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (acc_bypass) begin
            rsp_valid <= 1'b1; rsp_addr <= req_addr;
            rsp_err   <= 1'b0; rsp_coh  <= 1'b0;
          end else if (acc_hit) begin
            rsp_valid <= 1'b1; rsp_addr <= {c_frame, req_addr[PG_SH-1:0]};
            rsp_err   <= 1'b0; rsp_coh  <= c_coh;
          end else if (acc_miss) begin
            hold_q <= req_addr;
            slot_q <= pte_slot(tbl_f, req_addr, base_f);
            st_q   <= ST_FETCH;
          end
        end
        ST_FETCH: if (mem_req_ready) st_q <= ST_WAIT;
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            rsp_valid <= 1'b1;
            st_q      <= ST_IDLE;
            if (mem_rsp_data[0]) begin
              rsp_addr <= {pte_frame(mem_rsp_data), hold_q[PG_SH-1:0]};
              rsp_err  <= 1'b0;
              rsp_coh  <= mem_rsp_data[1];
            end else begin
              rsp_addr <= hold_q;
              rsp_err  <= 1'b1;
              rsp_coh  <= 1'b0;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R2: bypassed requests come back unchanged next cycle
  p_bypass_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_bypass |=> rsp_valid && !rsp_err && (rsp_addr == $past(req_addr)));
  // R2: a bypass never starts a table read
  p_bypass_nofetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_bypass |=> !mem_req_valid);
  // R4: read request held steady under back-pressure
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  // R6: an invalid entry yields an error response and the sticky flag
  p_err_resp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pte_bad |=> rsp_valid && rsp_err && err_flag);
  // R8: a hit answers next cycle without memory traffic
  p_hit_fast_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |=> rsp_valid && !rsp_err && !mem_req_valid);
  // R9: no acceptance while an invalidate is pending
  p_ready_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_pending |-> !req_ready);
  // R11: one request in flight
  p_one_inflight_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);
endmodule

// File: tb/test_aprt_xlate.sv
module test_aprt_xlate;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0; logic [7:0] cfg_addr = '0; logic [31:0] cfg_wdata = '0; logic [31:0] cfg_rdata;
  logic req_valid = 1'b0, req_ready, req_io = 1'b0; logic [39:0] req_addr = '0;
  logic rsp_valid, rsp_err, rsp_coh; logic [39:0] rsp_addr;
  logic mem_req_valid, mem_req_ready, mem_rsp_valid; logic [39:0] mem_req_addr; logic [31:0] mem_rsp_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  aprt_xlate #(.CACHE_ENTRIES(NC)) i_aprt_xlate (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .req_valid, .req_ready, .req_addr, .req_io,
    .rsp_valid, .rsp_addr, .rsp_err, .rsp_coh,
    .mem_req_valid, .mem_req_ready, .mem_req_addr, .mem_rsp_valid, .mem_rsp_data
  );

  int n_chk = 0, n_bad = 0;
  int fetch_cnt = 0;
  logic [39:0] hs_addr = '0;

  // bench model of software-visible state
  logic [5:0]  m_ctl = '0;
  logic [14:0] m_base = '0;
  logic [27:0] m_tbl = '0;
  logic        m_err = 1'b0;
  logic        c_v [NC];
  logic [27:0] c_pn [NC];
  int          c_ptr = 0;

  task automatic chk(input bit ok, input string rq, input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] pte_of(input logic [39:0] ea);
    logic [31:0] h;
    h = ea[31:0] * 32'h2545F491 + {ea[39:32], 24'h5A3C1};
    return {h[31:4], 2'b00, h[3], (ea[6:2] != 5'd7)};
  endfunction

  function automatic longint unsigned ap_start();
    return longint'(m_base) * 64'd33554432;
  endfunction
  function automatic longint unsigned ap_len();
    return 64'd33554432 * (64'd1 << m_ctl[3:1]);
  endfunction
  function automatic bit in_ap(input logic [39:0] a);
    return (64'(a) >= ap_start()) && (64'(a) < ap_start() + ap_len());
  endfunction

  // memory model: random ready, 1..3 cycle latency
  initial begin
    int lat; bit hs;
    lat = 0; hs = 0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (hs) begin lat = 1 + int'($urandom % 3); hs = 0; end
      if (lat > 0) begin
        lat--;
        if (lat == 0) begin mem_rsp_valid = 1'b1; mem_rsp_data = pte_of(hs_addr); end
      end
      mem_req_ready = (lat == 0) && ($urandom % 3 != 0);
      if (mem_req_valid && mem_req_ready) begin hs = 1; hs_addr = mem_req_addr; fetch_cnt++; end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    cfg_addr = a; #1; d = cfg_rdata;
  endtask

  task automatic model_flush();
    for (int i = 0; i < NC; i++) c_v[i] = 1'b0;
    c_ptr = 0;
  endtask

  task automatic set_cfg(input logic [5:0] c, input logic [14:0] b, input logic [27:0] t);
    wr(8'h90, {26'h0, c}); wr(8'h94, {17'h0, b}); wr(8'h98, {t, 4'h0});
    m_ctl = c; m_base = b; m_tbl = t;
    wr(8'h9C, 32'h1); @(negedge clk); model_flush();
  endtask

  task automatic run_req(input logic [39:0] a, input logic io, input string rq);
    bit on; int hitw, ef, f0, n; logic [39:0] ea, exp_a; logic [31:0] pte; logic exp_e, exp_c;
    on = m_ctl[0] && !(io ? m_ctl[5] : m_ctl[4]) && in_ap(a);
    ef = 0; exp_a = a; exp_e = 1'b0; exp_c = 1'b0; ea = '0;
    if (on) begin
      hitw = -1;
      for (int i = 0; i < NC; i++) if (c_v[i] && c_pn[i] == a[39:12]) hitw = i;
      ea  = 40'(longint'(m_tbl) * 4096 + (64'(a) - ap_start()) / 4096 * 4);
      pte = pte_of(ea);
      if (hitw < 0) ef = 1;
      if (pte[0]) begin
        exp_a = {pte[11:4], pte[31:12], a[11:0]}; exp_c = pte[1];
        if (hitw < 0) begin c_v[c_ptr] = 1'b1; c_pn[c_ptr] = a[39:12]; c_ptr = (c_ptr + 1) % NC; end
      end else begin
        exp_e = 1'b1; m_err = 1'b1;
      end
    end
    req_valid = 1'b1; req_addr = a; req_io = io;
    n = 0;
    while (!req_ready && n < 100) begin @(negedge clk); n++; end
    f0 = fetch_cnt;
    @(negedge clk); req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 100) begin @(negedge clk); n++; end
    chk(rsp_valid === 1'b1, {rq, " rsp_valid"}, rsp_valid, 1);
    chk(rsp_addr === exp_a, {rq, " rsp_addr"}, rsp_addr, exp_a);
    chk(rsp_err === exp_e && rsp_coh === exp_c, {rq, " err/coh"}, {rsp_err, rsp_coh}, {exp_e, exp_c});
    chk(fetch_cnt - f0 == ef, {rq, " table reads"}, fetch_cnt - f0, ef);
    if (ef == 1) chk(hs_addr === ea, {rq, " R4 entry address"}, hs_addr, ea);
    else chk(n == 0, {rq, " one-cycle answer"}, n, 0);
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] d; longint unsigned b;
    void'($urandom(32'd2024));
    for (int i = 0; i < NC; i++) begin c_v[i] = 1'b0; c_pn[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h90, d); chk(d == 0, "R1 reset ctl", d, 0);
    rd(8'h94, d); chk(d == 0, "R1 reset base", d, 0);
    rd(8'h98, d); chk(d == 0, "R1 reset table", d, 0);
    rd(8'h9C, d); chk(d == 0, "R1 reset cache ctl", d, 0);
    chk(req_ready && !rsp_valid && !mem_req_valid, "R11 idle after reset", {req_ready, rsp_valid, mem_req_valid}, 3'b100);
    // R1 field masks
    wr(8'h90, 32'hFFFF_FFFF); rd(8'h90, d); chk(d == 32'h3F, "R1 ctl mask", d, 32'h3F);
    wr(8'h94, 32'hFFFF_FFFF); rd(8'h94, d); chk(d == 32'h7FFF, "R1 base mask", d, 32'h7FFF);
    wr(8'h98, 32'hFFFF_FFFF); rd(8'h98, d); chk(d == 32'hFFFF_FFF0, "R1 table mask", d, 32'hFFFF_FFF0);
    rd(8'h40, d); chk(d == 0, "R1 unmapped offset", d, 0);

    // R2 translation off
    set_cfg(6'h00, 15'h0004, 28'h0000123);
    run_req(40'h00_0800_0040, 1'b0, "R2 disabled");
    set_cfg(6'h01, 15'h0004, 28'h0000123);
    b = ap_start();
    run_req(40'(b), 1'b0, "R5 first byte");
    run_req(40'(b + 64'h1C30), 1'b1, "R5 second page");
    run_req(40'(b + ap_len() - 1), 1'b0, "R3 last byte");
    run_req(40'(b + ap_len()), 1'b0, "R3 one past end");
    run_req(40'(b - 1), 1'b0, "R3 below start");
    run_req(40'(b + 64'h88), 1'b0, "R8 repeat hit");
    // R10 source disables
    set_cfg(6'h11, 15'h0004, 28'h0000123);
    run_req(40'(b + 64'h3000), 1'b0, "R10 cpu disabled");
    run_req(40'(b + 64'h3000), 1'b1, "R10 io allowed");
    set_cfg(6'h21, 15'h0004, 28'h0000123);
    run_req(40'(b + 64'h3000), 1'b1, "R10 io disabled");
    run_req(40'(b + 64'h3000), 1'b0, "R10 cpu allowed");
    // R6 invalid entry (page index 7)
    run_req(40'(b + 64'h7004), 1'b0, "R6 invalid entry");
    rd(8'h9C, d); chk(d[1] == 1'b1, "R6 error bit set", d[1], 1);
    run_req(40'(b + 64'h7008), 1'b0, "R6 refetch invalid");
    wr(8'h9C, 32'h0); rd(8'h9C, d); chk(d[1] == 1'b1, "R7 write 0 keeps error", d[1], 1);
    wr(8'h9C, 32'h2); m_err = 1'b0; rd(8'h9C, d); chk(d[1] == 1'b0, "R7 write 1 clears", d[1], 0);
    // R8 round robin: five pages into four ways
    for (int p = 8; p < 13; p++) run_req(40'(b + 64'(p) * 4096), 1'b0, "R8 fill");
    run_req(40'(b + 9 * 4096), 1'b0, "R8 survivor hits");
    run_req(40'(b + 8 * 4096), 1'b0, "R8 oldest evicted");
    // R9 invalidate
    wr(8'h9C, 32'h1);
    rd(8'h9C, d); chk(d[0] == 1'b1 && !req_ready, "R9 pending visible", {d[0], req_ready}, 2'b10);
    @(negedge clk);
    rd(8'h9C, d); chk(d[0] == 1'b0 && req_ready, "R9 pending cleared", {d[0], req_ready}, 2'b01);
    model_flush();
    run_req(40'(b + 10 * 4096), 1'b0, "R9 refetch after flush");
    // R3 largest order
    set_cfg(6'h0D, 15'h0040, 28'h0000777);
    b = ap_start();
    run_req(40'(b + ap_len() - 1), 1'b0, "R3 order 6 last byte");
    run_req(40'(b + ap_len()), 1'b1, "R3 order 6 past end");

    // random phase
    for (int it = 0; it < 400; it++) begin
      logic [39:0] a; longint unsigned pg;
      if (it % 50 == 0) begin
        logic [5:0] c;
        c = {($urandom % 5 == 0), ($urandom % 5 == 0), 3'($urandom % 7), ($urandom % 5 != 0)};
        set_cfg(c, 15'($urandom % 16384), 28'($urandom));
      end
      if ($urandom % 10 < 7) begin
        pg = ($urandom % 2 == 0) ? 64'($urandom % 12) : 64'($urandom) % (ap_len() / 4096);
        a = 40'(ap_start() + pg * 4096 + 64'($urandom % 4096));
      end else begin
        a = {8'($urandom), 32'($urandom)};
      end
      run_req(a, 1'($urandom), "R5 random");
      if (it % 40 == 39) begin
        rd(8'h9C, d); chk(d[1] == m_err, "R7 random error flag", d[1], m_err);
        wr(8'h9C, 32'h2); m_err = 1'b0;
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule